// File: doc/BRIEF.md
# Mailbox Register Access Bridge

This block sits on the target side of a narrow host link. It lets a host issue 32-bit register reads and writes against an internal peripheral bus by using only two host-visible words: a transfer word and a status word. The host writes a command into the transfer word. The command packs an 8-bit opcode and a 24-bit register address. For a write, the host then writes the data word to the same location. The bridge runs the access on its internal request/ack bus, queues the response words and raises a ready bit. The host reads the response words from the transfer location one at a time.

When the last response word has been read, ready falls and the bridge accepts the next command. A host that finds ready set before it has sent anything can read the transfer location until ready clears. This discards stale words and brings the bridge back to a clean state.

Top module: `mbox_bridge`

## Requirements
- R1: After reset the status word reads 0, a transfer read returns 0 and no bus request is driven.
- R2: A command word carries the opcode in bits 31:24 and the register address in bits 23:0. The bus address of the resulting access equals bits 23:0.
- R3: Opcode 0x01 issues exactly one bus read. Its response is two words read from the transfer location: status 0 first, then the value returned on the bus.
- R4: Opcode 0x10 takes the next transfer write as its data and issues no bus access before that word arrives. It then issues exactly one bus write carrying that data, and its response is a single status word of 0.
- R5: A bus request lasts exactly one cycle. Ready is not raised before the bus ack has been received.
- R6: Any other opcode starts no bus access and completes with a single status word of 0x00000001.
- R7: The status location reads ready in bit 0. All other bits read zero.
- R8: Each transfer read while ready is set consumes one response word. Ready stays set until the last word has been consumed and falls right after it.
- R9: Transfer writes made while an access is in flight or a response is pending have no effect: they change neither the response nor the bus activity.
- R10: A transfer read while ready is clear returns 0 and has no effect.
- R11: No new bus request is issued while a response is pending or an earlier request is still unacknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host write strobe, one cycle per word |
| host_rd_i | input | 1 | Host read strobe, one cycle per word |
| host_sel_i | input | 1 | Location select: 0 transfer word, 1 status word |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, valid in the strobe cycle |
| bus_req_o | output | 1 | One-cycle request on the internal register bus |
| bus_we_o | output | 1 | Request is a write |
| bus_addr_o | output | 24 | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with ack |
| bus_ack_i | input | 1 | Completion of the outstanding request |

## Verification
The assertions assume three things about the inputs. The host never raises its read and write strobes in the same cycle. The bus raises ack only after a request, and only once for each request. Each strobe covers one word. The bench honours this with tasks that drive one strobe for one cycle and with a bus responder that acks a single pending request after a latency of 0 to 3 extra cycles. Every one of the 256 opcode values is swept, each with its own address and latency.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WDATA,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } state_e;

  localparam int OPC_READ   = 'h01;
  localparam int OPC_WRITE  = 'h10;
  localparam int STAT_OK    = 0;
  localparam int STAT_BADOP = 1;
endpackage

// File: rtl/mbox_cmd_dec.sv
module mbox_cmd_dec #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic [DATA_W-1:0] cmd_i,
  output logic              is_rd_o,
  output logic              is_wr_o,
  output logic [ADDR_W-1:0] addr_o
);
  import mbox_pkg::*;
  localparam int OP_W = DATA_W - ADDR_W;

  logic [OP_W-1:0] op;
  assign op      = cmd_i[DATA_W-1:ADDR_W];
  assign addr_o  = cmd_i[ADDR_W-1:0];
  assign is_rd_o = (op == OP_W'(OPC_READ));
  assign is_wr_o = (op == OP_W'(OPC_WRITE));
endmodule

// File: rtl/mbox_resp_q.sv
module mbox_resp_q #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [CNT_W-1:0]              load_cnt_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]  load_data_i,
  input  logic                          pop_i,
  output logic [DATA_W-1:0]             head_o,
  output logic                          nonempty_o
);
  logic [DEPTH-1:0][DATA_W-1:0] slot_q;
  logic [CNT_W-1:0]             cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_cnt_i;
    else if (pop_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[i] <= '0;
      else if (load_i) slot_q[i] <= load_data_i[i];
      else if (pop_i) begin
        if (i == DEPTH - 1) slot_q[i] <= '0;
        else slot_q[i] <= slot_q[(i+1)%DEPTH];
      end
    end
  end

  assign head_o     = slot_q[0];
  assign nonempty_o = (cnt_q != '0);
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic              host_sel_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i
);
  import mbox_pkg::*;
  localparam int QDEPTH = 2;
  localparam int CNT_W  = $clog2(QDEPTH + 1);

  state_e            state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              dec_rd, dec_wr;
  logic [ADDR_W-1:0] dec_addr;
  logic              wr_xfer, rd_xfer, ready, pop, load;
  logic [CNT_W-1:0]  load_cnt;
  logic [QDEPTH-1:0][DATA_W-1:0] load_data;
  logic [DATA_W-1:0] head;

  assign wr_xfer = host_wr_i && !host_sel_i;
  assign rd_xfer = host_rd_i && !host_sel_i;
  assign pop     = rd_xfer && ready;

  mbox_cmd_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dec_i (
    .cmd_i   (host_wdata_i),
    .is_rd_o (dec_rd),
    .is_wr_o (dec_wr),
    .addr_o  (dec_addr)
  );

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_cnt  = CNT_W'(1);
    load_data = '0;
    case (state_q)
      ST_IDLE: if (wr_xfer) begin
        if (dec_rd) state_d = ST_ISSUE;
        else if (dec_wr) state_d = ST_WDATA;
        else begin
          load         = 1'b1;
          load_data[0] = DATA_W'(STAT_BADOP);
          state_d      = ST_RESP;
        end
      end
      ST_WDATA: if (wr_xfer) state_d = ST_ISSUE;
      ST_ISSUE, ST_WAIT: begin
        if (bus_ack_i) begin
          load         = 1'b1;
          load_cnt     = we_q ? CNT_W'(1) : CNT_W'(2);
          load_data[0] = DATA_W'(STAT_OK);
          load_data[1] = we_q ? '0 : bus_rdata_i;
          state_d      = ST_RESP;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_RESP: if (!ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && wr_xfer) begin
        we_q   <= dec_wr;
        addr_q <= dec_addr;
      end
      if (state_q == ST_WDATA && wr_xfer) wdata_q <= host_wdata_i;
    end
  end

  mbox_resp_q #(.DATA_W(DATA_W), .DEPTH(QDEPTH)) q_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_cnt_i  (load_cnt),
    .load_data_i (load_data),
    .pop_i       (pop),
    .head_o      (head),
    .nonempty_o  (ready)
  );

  assign bus_req_o    = (state_q == ST_ISSUE);
  assign bus_we_o     = we_q;
  assign bus_addr_o   = addr_q;
  assign bus_wdata_o  = wdata_q;
  assign host_rdata_o = host_sel_i ? DATA_W'(ready) : (ready ? head : '0);
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic              host_sel_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              bus_req_o,
  input logic              bus_ack_i,
  input logic              ready
);
  logic outstanding_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outstanding_q <= 1'b0;
    else if (bus_ack_i) outstanding_q <= 1'b0;
    else if (bus_req_o) outstanding_q <= 1'b1;
  end

  p_req_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |=> !bus_req_o);

  p_ready_needs_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready) |-> ($past(bus_ack_i) || $past(host_wr_i && !host_sel_i)));

  p_ready_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !(host_rd_i && !host_sel_i)) |=> ready);

  p_no_req_pending_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready || outstanding_q) |-> !bus_req_o);

  p_idle_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !host_sel_i && !ready) |-> (host_rdata_o == '0));

  p_status_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_sel_i) |-> (host_rdata_o[DATA_W-1:1] == '0 && host_rdata_o[0] == ready));
endmodule

bind mbox_bridge mbox_bridge_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .host_sel_i   (host_sel_i),
  .host_rdata_o (host_rdata_o),
  .bus_req_o    (bus_req_o),
  .bus_ack_i    (bus_ack_i),
  .ready        (ready)
);

// File: tb/mbox_bridge_tb.sv
module mbox_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;

  int tests = 0, fails = 0;
  int nreq = 0, wide = 0, overlap = 0;
  logic        last_we;
  logic [23:0] last_addr;
  logic [31:0] last_wdata;
  int lat = 0, cnt = 0;
  logic pend = 1'b0, req_prev = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_sel_i(host_sel),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack)
  );

  function automatic logic [31:0] model_rd(input logic [23:0] a);
    return {~a[7:0], a} ^ 32'h1357_9BDF;
  endfunction

  // bus responder: acks lat+1 cycles after the request
  always @(posedge clk) begin
    bus_ack <= 1'b0;
    req_prev <= bus_req;
    if (bus_req) begin
      if (req_prev) wide++;
      if (pend) overlap++;
      nreq++;
      last_we = bus_we; last_addr = bus_addr; last_wdata = bus_wdata;
      pend = 1'b1; cnt = lat;
    end else if (pend) begin
      if (cnt == 0) begin
        bus_ack <= 1'b1;
        bus_rdata <= model_rd(last_addr);
        pend = 1'b0;
      end else cnt--;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_sel = sel;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_ready(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 40; i++) begin
      hrd(1'b1, s);
      if (s[0]) return;
    end
    check({tag, " ready timeout"}, 32'h0, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    check("R1 bus_req after reset", 32'(bus_req), 0);
    rst_n = 1'b1;
    hrd(1'b1, d); check("R1 status after reset", d, 0);
    hrd(1'b0, d); check("R1 R10 idle transfer read", d, 0);
    hrd(1'b1, d); check("R10 idle read no effect", d, 0);

    for (int op = 0; op < 256; op++) begin
      logic [23:0] a;
      logic [31:0] wd;
      a   = {8'(op) ^ 8'hA5, 8'(op), ~8'(op)};
      wd  = {~a[15:0], 8'(op), 8'h5C};
      lat = op % 4;
      base = nreq;
      hwr(1'b0, {8'(op), a});
      if (op == 'h01) begin
        hrd(1'b1, d); check("R5 no ready before ack", d, 0);
        hwr(1'b0, 32'hDEAD_BEEF);  // R9 write while in flight
        wait_ready("R3");
        check("R3 one bus read", 32'(nreq - base), 1);
        check("R3 bus read we", 32'(last_we), 0);
        check("R2 read address", 32'(last_addr), 32'(a));
        hwr(1'b0, 32'h1000_0000);  // R9 write while pending
        hrd(1'b0, d); check("R3 status word", d, 0);
        hrd(1'b1, d); check("R8 ready held mid response", d, 1);
        hrd(1'b0, d); check("R3 R9 read value", d, model_rd(a));
        hrd(1'b1, d); check("R8 ready drops", d, 0);
        check("R9 no extra access", 32'(nreq - base), 1);
      end else if (op == 'h10) begin
        repeat (4) @(negedge clk);
        check("R4 no access before data", 32'(nreq - base), 0);
        hrd(1'b1, d); check("R4 not ready before data", d, 0);
        hwr(1'b0, wd);
        hrd(1'b1, d); check("R5 no ready before ack", d, 0);
        wait_ready("R4");
        check("R4 one bus write", 32'(nreq - base), 1);
        check("R4 bus write we", 32'(last_we), 1);
        check("R2 write address", 32'(last_addr), 32'(a));
        check("R4 write data", last_wdata, wd);
        hwr(1'b0, 32'h0100_0000);  // R9 ignored
        hrd(1'b0, d); check("R4 status word", d, 0);
        hrd(1'b1, d); check("R8 ready drops", d, 0);
        hrd(1'b0, d); check("R10 read after drain", d, 0);
        repeat (6) @(negedge clk);
        check("R9 no access from ignored write", 32'(nreq - base), 1);
      end else begin
        wait_ready("R6");
        hrd(1'b0, d); check("R6 bad opcode status", d, 1);
        hrd(1'b1, d); check("R6 R8 ready drops", d, 0);
        check("R6 no bus access", 32'(nreq - base), 0);
      end
    end

    // flush: over-read a read response
    lat = 2; base = nreq;
    hwr(1'b0, {8'h01, 24'h00_0ABC});
    wait_ready("R8 flush");
    hrd(1'b0, d); hrd(1'b0, d);
    hrd(1'b0, d); check("R10 read past end", d, 0);
    hrd(1'b1, d); check("R8 flushed", d, 0);
    check("R11 single access on flush", 32'(nreq - base), 1);

    check("R5 request width", 32'(wide), 0);
    check("R11 no overlapping request", 32'(overlap), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule